// File: doc/BRIEF.md
# Protection Switch Control Arbiter

This block sets the enable lines of two low-side protection switches, one in the charge path and one in the discharge path. It merges an autonomous decision, derived from the vector of active protection faults, with manual requests from a host. Each fault has two routing mask bits: one picks the charge switch and one picks the discharge switch. A fault with both bits set opens both switches. A fault with neither bit set has no effect on either switch.

Autonomous control works only while an internal autonomous-enable flag is set. The flag has a reset value given by a parameter. A configuration load strobe writes a new value into it, and a command strobe inverts it. The host can force either switch off or on through level request bits. Each kind of request takes effect only while its own permission bit is set. A permitted force-off always wins. A permitted force-on overrides the autonomous result. With no permitted host request, the switch follows the autonomous decision. Every output is registered, so a change at the inputs shows at the outputs one clock later.

Top module: `prot_switch_arbiter`

## Requirements
- R1: While reset is asserted and until the first clock edge after its release, both switch enables are 0 and the autonomous-enable status equals the parameter AUTO_EN_RST (default 1).
- R2: A cycle with the toggle strobe high and the load strobe low inverts the autonomous-enable status at the next clock edge.
- R3: A cycle with the load strobe high sets the autonomous-enable status to the configuration value at the next clock edge, whatever the toggle strobe does.
- R4: With autonomous control enabled and no permitted host request, each switch enable after an edge is 1 exactly when no fault bit i was active together with that switch's mask bit i in the cycle before. Charge uses mask vector chg_mask_i and discharge uses dsg_mask_i.
- R5: A fault whose bit is set in both masks opens both switches. A fault whose bit is clear in both masks leaves both switches closed.
- R6: With autonomous control disabled and no permitted host force-on, both switch enables are 0 after the next edge.
- R7: When the host turn-off permission is 1 and the force-off request for a switch is 1, that switch enable is 0 after the next edge.
- R8: A host force-off request while the turn-off permission is 0 has no effect on the switch enable.
- R9: When the host turn-on permission is 1 and a switch's force-on request is 1 with no permitted force-off for it, that switch enable is 1 after the next edge, even with a mapped fault active or autonomous control disabled.
- R10: A host force-on request while the turn-on permission is 0 has no effect on the switch enable.
- R11: When a switch has both a permitted force-off and a permitted force-on at the same time, its enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fault_i | input | NUM_FAULTS | Active protection faults, one bit per protection |
| chg_mask_i | input | NUM_FAULTS | Bit i set: fault i opens the charge switch |
| dsg_mask_i | input | NUM_FAULTS | Bit i set: fault i opens the discharge switch |
| auto_cfg_i | input | 1 | Value written into the autonomous-enable flag by a load |
| auto_load_i | input | 1 | Load strobe for the autonomous-enable flag |
| auto_toggle_i | input | 1 | Command strobe that inverts the autonomous-enable flag |
| host_off_chg_i | input | 1 | Host force-off request, charge switch |
| host_off_dsg_i | input | 1 | Host force-off request, discharge switch |
| host_on_chg_i | input | 1 | Host force-on request, charge switch |
| host_on_dsg_i | input | 1 | Host force-on request, discharge switch |
| host_off_allow_i | input | 1 | Permission for host force-off requests |
| host_on_allow_i | input | 1 | Permission for host force-on requests |
| chg_en_o | output | 1 | Charge switch enable |
| dsg_en_o | output | 1 | Discharge switch enable |
| auto_en_o | output | 1 | Current autonomous-enable flag |

## Verification
The hardest case to reach is a host request that conflicts with the autonomous result while its permission bit is clear. It happens only when an active fault, a particular mask pattern, the autonomous flag value and several host request bits line up in a single cycle. The bench reaches it by sweeping every combination of the four request bits, the two permission bits, the autonomous flag, all fault patterns and sixteen mask pairs of a four-fault build. It first sets the autonomous flag through the load strobe. The toggle and load ordering is exercised separately, including both strobes in the same cycle.

// File: rtl/psw_pkg.sv
package psw_pkg;
    localparam int NUM_SW = 2;
    localparam int SW_CHG = 0;
    localparam int SW_DSG = 1;

    typedef logic [NUM_SW-1:0] sw_vec_t;

    typedef struct packed {
        logic    auto_en;
        sw_vec_t sw_en;
    } arb_state_t;
endpackage

// File: rtl/psw_fault_route.sv
module psw_fault_route
    import psw_pkg::*;
#(
    parameter int NUM_FAULTS = 16
) (
    input  logic [NUM_FAULTS-1:0]             fault_i,
    input  logic [NUM_SW-1:0][NUM_FAULTS-1:0] mask_i,
    output sw_vec_t                           trip_o
);
    timeunit 1ns; timeprecision 1ps;

    // One OR reduction per switch over the faults routed to it
    for (genvar s = 0; s < NUM_SW; s++) begin : g_sw
        assign trip_o[s] = |(fault_i & mask_i[s]);
    end
endmodule

// File: rtl/psw_host_gate.sv
module psw_host_gate
    import psw_pkg::*;
(
    input  sw_vec_t off_req_i,
    input  sw_vec_t on_req_i,
    input  logic    off_allow_i,
    input  logic    on_allow_i,
    output sw_vec_t force_off_o,
    output sw_vec_t force_on_o
);
    timeunit 1ns; timeprecision 1ps;

    // Permission gating; a permitted force-off masks any force-on
    for (genvar s = 0; s < NUM_SW; s++) begin : g_sw
        assign force_off_o[s] = off_req_i[s] & off_allow_i;
        assign force_on_o[s]  = on_req_i[s] & on_allow_i & ~force_off_o[s];
    end
endmodule

// File: rtl/prot_switch_arbiter.sv
module prot_switch_arbiter
    import psw_pkg::*;
#(
    parameter int   NUM_FAULTS  = 16,
    parameter logic AUTO_EN_RST = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_FAULTS-1:0] fault_i,
    input  logic [NUM_FAULTS-1:0] chg_mask_i,
    input  logic [NUM_FAULTS-1:0] dsg_mask_i,
    input  logic                  auto_cfg_i,
    input  logic                  auto_load_i,
    input  logic                  auto_toggle_i,
    input  logic                  host_off_chg_i,
    input  logic                  host_off_dsg_i,
    input  logic                  host_on_chg_i,
    input  logic                  host_on_dsg_i,
    input  logic                  host_off_allow_i,
    input  logic                  host_on_allow_i,
    output logic                  chg_en_o,
    output logic                  dsg_en_o,
    output logic                  auto_en_o
);
    timeunit 1ns; timeprecision 1ps;

    localparam arb_state_t STATE_RST = '{auto_en: AUTO_EN_RST, sw_en: '0};

    logic [NUM_SW-1:0][NUM_FAULTS-1:0] mask_w;
    sw_vec_t    trip_w;
    sw_vec_t    off_req_w, on_req_w;
    sw_vec_t    force_off_w, force_on_w;
    arb_state_t st_d, st_q;

    always_comb begin
        mask_w         = '0;
        mask_w[SW_CHG] = chg_mask_i;
        mask_w[SW_DSG] = dsg_mask_i;
        off_req_w         = '0;
        off_req_w[SW_CHG] = host_off_chg_i;
        off_req_w[SW_DSG] = host_off_dsg_i;
        on_req_w          = '0;
        on_req_w[SW_CHG]  = host_on_chg_i;
        on_req_w[SW_DSG]  = host_on_dsg_i;
    end

    psw_fault_route #(.NUM_FAULTS(NUM_FAULTS)) u_route (
        .fault_i (fault_i),
        .mask_i  (mask_w),
        .trip_o  (trip_w)
    );

    psw_host_gate u_gate (
        .off_req_i   (off_req_w),
        .on_req_i    (on_req_w),
        .off_allow_i (host_off_allow_i),
        .on_allow_i  (host_on_allow_i),
        .force_off_o (force_off_w),
        .force_on_o  (force_on_w)
    );

    // Next-state: flag update, then per-switch arbitration
    always_comb begin
        st_d = st_q;
        if (auto_load_i) begin
            st_d.auto_en = auto_cfg_i;
        end else if (auto_toggle_i) begin
            st_d.auto_en = ~st_q.auto_en;
        end
        for (int s = 0; s < NUM_SW; s++) begin
            st_d.sw_en[s] = ~force_off_w[s]
                          & (force_on_w[s] | (st_q.auto_en & ~trip_w[s]));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= STATE_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign chg_en_o  = st_q.sw_en[SW_CHG];
    assign dsg_en_o  = st_q.sw_en[SW_DSG];
    assign auto_en_o = st_q.auto_en;
endmodule

// File: rtl/psw_arbiter_checker.sv
module psw_arbiter_checker #(
    parameter int NUM_FAULTS = 16
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [NUM_FAULTS-1:0] fault_i,
    input logic [NUM_FAULTS-1:0] chg_mask_i,
    input logic [NUM_FAULTS-1:0] dsg_mask_i,
    input logic                  auto_cfg_i,
    input logic                  auto_load_i,
    input logic                  auto_toggle_i,
    input logic                  host_off_chg_i,
    input logic                  host_off_dsg_i,
    input logic                  host_on_chg_i,
    input logic                  host_on_dsg_i,
    input logic                  host_off_allow_i,
    input logic                  host_on_allow_i,
    input logic                  chg_en_o,
    input logic                  dsg_en_o,
    input logic                  auto_en_o
);
    timeunit 1ns; timeprecision 1ps;

    p_toggle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_toggle_i && !auto_load_i) |=> (auto_en_o != $past(auto_en_o)));

    p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        auto_load_i |=> (auto_en_o == $past(auto_cfg_i)));

    p_auto_chg_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_en_o && !host_off_allow_i && !host_on_allow_i)
        |=> (chg_en_o == !$past(|(fault_i & chg_mask_i))));

    p_auto_dsg_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_en_o && !host_off_allow_i && !host_on_allow_i)
        |=> (dsg_en_o == !$past(|(fault_i & dsg_mask_i))));

    p_manual_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!auto_en_o && !host_on_allow_i) |=> (!chg_en_o && !dsg_en_o));

    p_off_chg_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (host_off_allow_i && host_off_chg_i) |=> !chg_en_o);

    p_off_dsg_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (host_off_allow_i && host_off_dsg_i) |=> !dsg_en_o);

    p_on_chg_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (host_on_allow_i && host_on_chg_i && !(host_off_allow_i && host_off_chg_i))
        |=> chg_en_o);

    p_on_dsg_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (host_on_allow_i && host_on_dsg_i && !(host_off_allow_i && host_off_dsg_i))
        |=> dsg_en_o);
endmodule

bind prot_switch_arbiter psw_arbiter_checker #(.NUM_FAULTS(NUM_FAULTS)) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .fault_i          (fault_i),
    .chg_mask_i       (chg_mask_i),
    .dsg_mask_i       (dsg_mask_i),
    .auto_cfg_i       (auto_cfg_i),
    .auto_load_i      (auto_load_i),
    .auto_toggle_i    (auto_toggle_i),
    .host_off_chg_i   (host_off_chg_i),
    .host_off_dsg_i   (host_off_dsg_i),
    .host_on_chg_i    (host_on_chg_i),
    .host_on_dsg_i    (host_on_dsg_i),
    .host_off_allow_i (host_off_allow_i),
    .host_on_allow_i  (host_on_allow_i),
    .chg_en_o         (chg_en_o),
    .dsg_en_o         (dsg_en_o),
    .auto_en_o        (auto_en_o)
);

// File: tb/prot_switch_arbiter_bench.sv
module prot_switch_arbiter_bench;
    timeunit 1ns; timeprecision 1ps;

    localparam int NF = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NF-1:0] fault = '0, chg_mask = '0, dsg_mask = '0;
    logic          auto_cfg = 1'b0, auto_load = 1'b0, auto_toggle = 1'b0;
    logic          off_chg = 1'b0, off_dsg = 1'b0, on_chg = 1'b0, on_dsg = 1'b0;
    logic          off_allow = 1'b0, on_allow = 1'b0;
    logic          chg_en, dsg_en, auto_en;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    prot_switch_arbiter #(.NUM_FAULTS(NF), .AUTO_EN_RST(1'b1)) u_prot_switch_arbiter (
        .clk              (clk),
        .rst_n            (rst_n),
        .fault_i          (fault),
        .chg_mask_i       (chg_mask),
        .dsg_mask_i       (dsg_mask),
        .auto_cfg_i       (auto_cfg),
        .auto_load_i      (auto_load),
        .auto_toggle_i    (auto_toggle),
        .host_off_chg_i   (off_chg),
        .host_off_dsg_i   (off_dsg),
        .host_on_chg_i    (on_chg),
        .host_on_dsg_i    (on_dsg),
        .host_off_allow_i (off_allow),
        .host_on_allow_i  (on_allow),
        .chg_en_o         (chg_en),
        .dsg_en_o         (dsg_en),
        .auto_en_o        (auto_en)
    );

    task automatic check(input string req, input string what, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    // One clock: inputs already driven at a falling edge; sample at the next one
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic string tag(input logic a, input logic offr, input logic onr,
                                  input logic offp, input logic onp, input logic trip);
        if (offr && offp && onr && onp) return "R11";
        if (offr && offp)               return "R7";
        if (onr && onp)                 return "R9";
        if (offr)                       return "R8";
        if (onr)                        return "R10";
        if (!a)                         return "R6";
        if (trip)                       return "R5";
        return "R4";
    endfunction

    function automatic logic model(input logic a, input logic offr, input logic onr,
                                   input logic offp, input logic onp, input logic trip);
        if (offr && offp) return 1'b0;
        if (onr && onp)   return 1'b1;
        return a & ~trip;
    endfunction

    initial begin
        #1_500_000;
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        #22;
        check("R1", "chg_en in reset", chg_en, 1'b0);
        check("R1", "dsg_en in reset", dsg_en, 1'b0);
        check("R1", "auto_en in reset", auto_en, 1'b1);
        @(negedge clk);
        rst_n = 1'b1;
        check("R1", "chg_en after release", chg_en, 1'b0);

        // R2: toggle twice
        auto_toggle = 1'b1;
        step();
        check("R2", "toggle to 0", auto_en, 1'b0);
        step();
        check("R2", "toggle to 1", auto_en, 1'b1);
        auto_toggle = 1'b0;

        // R3: load beats toggle
        auto_load = 1'b1; auto_toggle = 1'b1; auto_cfg = 1'b1;
        step();
        check("R3", "load 1 with toggle", auto_en, 1'b1);
        auto_cfg = 1'b0;
        step();
        check("R3", "load 0 with toggle", auto_en, 1'b0);
        auto_load = 1'b0; auto_toggle = 1'b0;

        // R5: a fault routed to both, and an unrouted fault
        auto_load = 1'b1; auto_cfg = 1'b1;
        step();
        auto_load = 1'b0;
        chg_mask = 4'b0100; dsg_mask = 4'b0100; fault = 4'b0100;
        step();
        check("R5", "both-mapped fault chg", chg_en, 1'b0);
        check("R5", "both-mapped fault dsg", dsg_en, 1'b0);
        chg_mask = '0; dsg_mask = '0; fault = 4'b1111;
        step();
        check("R5", "unmapped fault chg", chg_en, 1'b1);
        check("R5", "unmapped fault dsg", dsg_en, 1'b1);

        // Sweep: flag x host bits x faults x mask pairs
        for (int a = 0; a < 2; a++) begin
            auto_load = 1'b1; auto_cfg = a[0];
            fault = '0; {off_chg, off_dsg, on_chg, on_dsg, off_allow, on_allow} = '0;
            step();
            auto_load = 1'b0;
            check("R3", "sweep flag load", auto_en, a[0]);
            for (int h = 0; h < 64; h++) begin
                for (int m = 0; m < 16; m++) begin
                    for (int f = 0; f < 16; f++) begin
                        logic [3:0] cm, dm;
                        logic tc, td, ec, ed;
                        cm = m[3:0];
                        dm = {m[1:0], m[3:2]} ^ 4'b0101;
                        {off_chg, off_dsg, on_chg, on_dsg, off_allow, on_allow} = h[5:0];
                        chg_mask = cm; dsg_mask = dm; fault = f[3:0];
                        tc = |(f[3:0] & cm);
                        td = |(f[3:0] & dm);
                        ec = model(a[0], h[5], h[3], h[1], h[0], tc);
                        ed = model(a[0], h[4], h[2], h[1], h[0], td);
                        step();
                        check(tag(a[0], h[5], h[3], h[1], h[0], tc), "sweep chg_en", chg_en, ec);
                        check(tag(a[0], h[4], h[2], h[1], h[0], td), "sweep dsg_en", dsg_en, ed);
                    end
                end
            end
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule